// File: doc/BRIEF.md
# Byte-per-word memory bridge

This block connects a 32-bit, byte-addressed slave port to a memory that stores only 8 bits per entry. Requests use a plain valid/ready handshake. Each memory byte takes up one full 32-bit word slot on the bus. Stepping the bus address by four therefore moves to the next memory entry, and the two low address bits play no part in choosing the entry.

A build-time placement mode sets how the stored byte appears in the 32-bit read data, and which write lane feeds the memory. The three choices are:
- the least significant lane only;
- the most significant lane only;
- all four lanes replicated.

The memory is an internal synchronous single-port model with one clock of read latency. The bridge covers a window that starts at a parameterised base and is four times the memory depth in size. Requests outside that window are still accepted, but they do not touch the memory.

Top module: `narrow_mem_bridge`

## Requirements
- R1: A request at bus address A inside the window reaches memory entry (A - BASE_ADDR) >> 2, so bus addresses BASE_ADDR+0x0, +0x4 and +0x8 reach entries 0, 1 and 2.
- R2: Address bits 1:0 are ignored. Any low-bit value reaches the same entry as the aligned address.
- R3: In the least-significant placement mode, read data carries the byte on bits 7:0 and zero on bits 31:8.
- R4: In the most-significant placement mode, read data carries the byte on bits 31:24 and zero on bits 23:0.
- R5: In the replicate placement mode, read data carries the byte on all four lanes (31:24, 23:16, 15:8, 7:0).
- R6: A write stores wdata[7:0] only when be[0] is set, in the least-significant mode. In the most-significant mode it stores wdata[31:24] only when be[3] is set. Otherwise the entry keeps its value.
- R7: In the replicate mode, a write stores the lane of the lowest set bit of be (be[i] selects wdata[8*i+7:8*i]). With be equal to zero, nothing is written.
- R8: A read accepted on a clock edge gives rsp_valid_o high for exactly the following cycle. An accepted write gives no response pulse.
- R9: req_ready_o is low while a read response is pending. A request presented while req_ready_o is low is not accepted and has no effect.
- R10: The window spans MEM_DEPTH*4 bytes from BASE_ADDR. An access outside it is accepted. An outside read returns zero, and an outside write changes no entry.
- R11: While rst_ni is low, req_ready_o is high and rsp_valid_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request can be accepted |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 32 | Byte address |
| req_wdata_i | input | 32 | Write data |
| req_be_i | input | 4 | Byte enables, one per lane |
| rsp_valid_o | output | 1 | Read data valid |
| rsp_rdata_o | output | 32 | Read data |

## Verification
The bench reads every entry through all four low-bit offsets. A bridge that kept the byte address, or used the low bits, would return a neighbour's byte.

It runs three instances, one per placement mode, on the same stimulus. Writes with single-lane enables such as 4'b0100, or with no enables at all, show a mode that picks the wrong lane or ignores the enables: a later read returns a changed byte.

Writes just past the window end and just below the base catch a bridge that wraps the index into memory, because they corrupt aliased entries. Holding a request valid while a read is pending catches a bridge that accepts while it is not ready, because the held write then lands.

// File: rtl/bridge_pkg.sv
package bridge_pkg;
  typedef enum logic [1:0] {
    LANE_LO  = 2'd0,
    LANE_HI  = 2'd1,
    LANE_REP = 2'd2
  } lane_mode_e;
endpackage

// File: rtl/nmb_addr_map.sv
module nmb_addr_map #(
  parameter logic [31:0] BASE_ADDR = 32'h0001_0000,
  parameter int unsigned MEM_DEPTH = 4096,
  localparam int unsigned AW       = $clog2(MEM_DEPTH)
) (
  input  logic [31:0]   addr_i,
  output logic          hit_o,
  output logic [AW-1:0] idx_o
);
  localparam logic [31:0] WinBytes = 32'(MEM_DEPTH) * 32'd4;

  logic [31:0] off;
  assign off   = addr_i - BASE_ADDR;
  assign hit_o = (addr_i >= BASE_ADDR) && (off < WinBytes);
  // word-scaled: each byte entry owns 4 bus addresses
  assign idx_o = off[AW+1:2];
endmodule

// File: rtl/nmb_lane_steer.sv
module nmb_lane_steer #(
  parameter bridge_pkg::lane_mode_e LANE_MODE = bridge_pkg::LANE_LO
) (
  input  logic [31:0] wdata_i,
  input  logic [3:0]  be_i,
  output logic [7:0]  wbyte_o,
  output logic        wen_o,
  input  logic [7:0]  rbyte_i,
  output logic [31:0] rdata_o
);
  if (LANE_MODE == bridge_pkg::LANE_LO) begin : g_lo
    logic unused_lanes;
    assign unused_lanes = ^{wdata_i[31:8], be_i[3:1]};
    assign wbyte_o = wdata_i[7:0];
    assign wen_o   = be_i[0];
    assign rdata_o = {24'h0, rbyte_i};
  end else if (LANE_MODE == bridge_pkg::LANE_HI) begin : g_hi
    logic unused_lanes;
    assign unused_lanes = ^{wdata_i[23:0], be_i[2:0]};
    assign wbyte_o = wdata_i[31:24];
    assign wen_o   = be_i[3];
    assign rdata_o = {rbyte_i, 24'h0};
  end else begin : g_rep
    // lowest enabled lane wins
    always_comb begin
      wbyte_o = 8'h00;
      for (int i = 3; i >= 0; i--) begin
        if (be_i[i]) wbyte_o = wdata_i[8*i +: 8];
      end
    end
    assign wen_o   = |be_i;
    assign rdata_o = {4{rbyte_i}};
  end
endmodule

// File: rtl/nmb_sync_ram.sv
module nmb_sync_ram #(
  parameter int unsigned DEPTH = 4096,
  parameter int unsigned DW    = 8,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic          re_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[addr_i] <= wdata_i;
    if (re_i) rdata_o <= mem_q[addr_i];
  end
endmodule

// File: rtl/narrow_mem_bridge.sv
module narrow_mem_bridge #(
  parameter logic [31:0]            BASE_ADDR = 32'h0001_0000,
  parameter int unsigned            MEM_DEPTH = 4096,
  parameter bridge_pkg::lane_mode_e LANE_MODE = bridge_pkg::LANE_LO
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_valid_i,
  output logic        req_ready_o,
  input  logic        req_we_i,
  input  logic [31:0] req_addr_i,
  input  logic [31:0] req_wdata_i,
  input  logic [3:0]  req_be_i,
  output logic        rsp_valid_o,
  output logic [31:0] rsp_rdata_o
);
  localparam int unsigned AW = $clog2(MEM_DEPTH);

  logic          accept, hit, lane_wen, ram_we, ram_re;
  logic [AW-1:0] idx;
  logic [7:0]    wbyte, rbyte;
  logic [31:0]   placed;
  logic          rd_pend_q, hit_q;

  nmb_addr_map #(.BASE_ADDR(BASE_ADDR), .MEM_DEPTH(MEM_DEPTH)) u_map (
    .addr_i(req_addr_i), .hit_o(hit), .idx_o(idx)
  );

  nmb_lane_steer #(.LANE_MODE(LANE_MODE)) u_steer (
    .wdata_i(req_wdata_i), .be_i(req_be_i), .wbyte_o(wbyte), .wen_o(lane_wen),
    .rbyte_i(rbyte), .rdata_o(placed)
  );

  assign req_ready_o = ~rd_pend_q;
  assign accept      = req_valid_i & req_ready_o;
  assign ram_we      = accept & req_we_i & hit & lane_wen;
  assign ram_re      = accept & ~req_we_i & hit;

  nmb_sync_ram #(.DEPTH(MEM_DEPTH), .DW(8)) u_ram (
    .clk_i(clk_i), .we_i(ram_we), .re_i(ram_re), .addr_i(idx),
    .wdata_i(wbyte), .rdata_o(rbyte)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_pend_q <= 1'b0;
      hit_q     <= 1'b0;
    end else begin
      rd_pend_q <= accept & ~req_we_i;
      hit_q     <= hit;
    end
  end

  assign rsp_valid_o = rd_pend_q;
  // misses read as zero
  assign rsp_rdata_o = (rd_pend_q && hit_q) ? placed : 32'h0;
endmodule

// File: rtl/narrow_mem_bridge_checker.sv
module narrow_mem_bridge_checker #(
  parameter logic [31:0]            BASE_ADDR = 32'h0001_0000,
  parameter int unsigned            MEM_DEPTH = 4096,
  parameter bridge_pkg::lane_mode_e LANE_MODE = bridge_pkg::LANE_LO
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        req_valid_i,
  input logic        req_ready_o,
  input logic        req_we_i,
  input logic [31:0] req_addr_i,
  input logic        rsp_valid_o,
  input logic [31:0] rsp_rdata_o
);
  localparam logic [31:0] LastAddr = BASE_ADDR + 32'(MEM_DEPTH) * 32'd4 - 32'd1;
  logic acc;
  logic outside;
  assign acc     = req_valid_i && req_ready_o;
  assign outside = (req_addr_i < BASE_ADDR) || (req_addr_i > LastAddr);

  assert_reset_idle_R11: assert property (@(posedge clk_i)
    !rst_ni |-> (req_ready_o && !rsp_valid_o));

  assert_read_rsp_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && !req_we_i) |=> rsp_valid_o);

  assert_write_no_rsp_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && req_we_i) |=> !rsp_valid_o);

  assert_busy_not_ready_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> !req_ready_o);

  assert_miss_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && !req_we_i && outside) |=> (rsp_rdata_o == 32'h0));

  if (LANE_MODE == bridge_pkg::LANE_LO) begin : g_lo
    assert_lo_upper_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rsp_valid_o |-> (rsp_rdata_o[31:8] == 24'h0));
  end else if (LANE_MODE == bridge_pkg::LANE_HI) begin : g_hi
    assert_hi_lower_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rsp_valid_o |-> (rsp_rdata_o[23:0] == 24'h0));
  end else begin : g_rep
    assert_rep_lanes_equal_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rsp_valid_o |-> (rsp_rdata_o == {4{rsp_rdata_o[7:0]}}));
  end
endmodule

bind narrow_mem_bridge narrow_mem_bridge_checker #(
  .BASE_ADDR(BASE_ADDR), .MEM_DEPTH(MEM_DEPTH), .LANE_MODE(LANE_MODE)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i),
  .req_ready_o(req_ready_o), .req_we_i(req_we_i), .req_addr_i(req_addr_i),
  .rsp_valid_o(rsp_valid_o), .rsp_rdata_o(rsp_rdata_o)
);

// File: tb/narrow_mem_bridge_bench.sv
module narrow_mem_bridge_bench;
  localparam logic [31:0] BASE  = 32'h0001_0000;
  localparam int          DEPTH = 64;
  localparam logic [31:0] WIN   = 32'(DEPTH) * 32'd4;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        req_we_i = 1'b0;
  logic [31:0] req_addr_i = '0;
  logic [31:0] req_wdata_i = '0;
  logic [3:0]  req_be_i = '0;
  logic [2:0]  rdy, vld;
  logic [31:0] rd [3];

  always #5 clk_i = ~clk_i;

  narrow_mem_bridge #(.BASE_ADDR(BASE), .MEM_DEPTH(DEPTH), .LANE_MODE(bridge_pkg::LANE_LO))
  u_narrow_mem_bridge (.clk_i, .rst_ni, .req_valid_i, .req_ready_o(rdy[0]), .req_we_i,
    .req_addr_i, .req_wdata_i, .req_be_i, .rsp_valid_o(vld[0]), .rsp_rdata_o(rd[0]));
  narrow_mem_bridge #(.BASE_ADDR(BASE), .MEM_DEPTH(DEPTH), .LANE_MODE(bridge_pkg::LANE_HI))
  u_narrow_mem_bridge_hi (.clk_i, .rst_ni, .req_valid_i, .req_ready_o(rdy[1]), .req_we_i,
    .req_addr_i, .req_wdata_i, .req_be_i, .rsp_valid_o(vld[1]), .rsp_rdata_o(rd[1]));
  narrow_mem_bridge #(.BASE_ADDR(BASE), .MEM_DEPTH(DEPTH), .LANE_MODE(bridge_pkg::LANE_REP))
  u_narrow_mem_bridge_rep (.clk_i, .rst_ni, .req_valid_i, .req_ready_o(rdy[2]), .req_we_i,
    .req_addr_i, .req_wdata_i, .req_be_i, .rsp_valid_o(vld[2]), .rsp_rdata_o(rd[2]));

  logic [7:0] model [3][DEPTH];
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  function automatic bit in_win(logic [31:0] a);
    return (a >= BASE) && (a - BASE < WIN);
  endfunction

  function automatic int idx_of(logic [31:0] a);
    return int'((a - BASE) >> 2);
  endfunction

  function automatic logic [31:0] place(int m, logic [7:0] b);
    case (m)
      0:       return {24'h0, b};
      1:       return {b, 24'h0};
      default: return {4{b}};
    endcase
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_write(logic [31:0] a, logic [31:0] d, logic [3:0] be);
    @(negedge clk_i);
    req_valid_i = 1; req_we_i = 1; req_addr_i = a; req_wdata_i = d; req_be_i = be;
    @(posedge clk_i);
    if (in_win(a)) begin
      if (be[0]) model[0][idx_of(a)] = d[7:0];
      if (be[3]) model[1][idx_of(a)] = d[31:24];
      for (int i = 3; i >= 0; i--) if (be == (4'b1 << i) || (be[i] && (be & ((4'b1 << i) - 1)) == 0))
        model[2][idx_of(a)] = d[8*i +: 8];
    end
    @(negedge clk_i);
    req_valid_i = 0;
    check("R8 no rsp after write", {29'h0, vld}, 32'h0);
  endtask

  task automatic do_read(logic [31:0] a, string req);
    @(negedge clk_i);
    req_valid_i = 1; req_we_i = 0; req_addr_i = a;
    @(posedge clk_i);
    @(negedge clk_i);
    req_valid_i = 0;
    check("R8 rsp valid", {29'h0, vld}, 32'h7);
    check("R9 ready low while pending", {29'h0, rdy}, 32'h0);
    for (int m = 0; m < 3; m++)
      check(req, rd[m], in_win(a) ? place(m, model[m][idx_of(a)]) : 32'h0);
    @(negedge clk_i);
    check("R8 single-cycle rsp", {29'h0, vld}, 32'h0);
    check("R9 ready back", {29'h0, rdy}, 32'h7);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk_i);
    check("R11 reset ready", {29'h0, rdy}, 32'h7);
    check("R11 reset rsp_valid", {29'h0, vld}, 32'h0);
    rst_ni = 1;
    // fill every entry (R1)
    for (int i = 0; i < DEPTH; i++) do_write(BASE + 4 * i, $urandom, 4'hF);
    for (int i = 0; i < DEPTH; i++) do_read(BASE + 4 * i, "R1 aligned read R3 R4 R5");
    for (int i = 0; i < 8; i++)
      for (int lo = 1; lo < 4; lo++) do_read(BASE + 4 * i + lo, "R2 low bits ignored");
    // lane selection corner cases (R6, R7)
    do_write(BASE + 4 * 5, 32'hA1B2C3D4, 4'b0100);
    do_read(BASE + 4 * 5, "R6 R7 be=0100");
    do_write(BASE + 4 * 6, 32'h11223344, 4'b0000);
    do_read(BASE + 4 * 6, "R7 be=0 no write");
    do_write(BASE + 4 * 7, 32'h55667788, 4'b1010);
    do_read(BASE + 4 * 7, "R6 R7 be=1010");
    do_write(BASE + 4 * 8, 32'h99AABBCC, 4'b1000);
    do_read(BASE + 4 * 8, "R6 R7 be=1000");
    do_write(BASE + 4 * 9 + 3, 32'hDEADBEEF, 4'b0001);
    do_read(BASE + 4 * 9, "R2 R6 write with low bits");
    // outside window (R10)
    do_write(BASE + WIN, 32'hFFFFFFFF, 4'hF);
    do_write(BASE + WIN + 4 * 3, 32'hFFFFFFFF, 4'hF);
    do_write(BASE - 4, 32'hFFFFFFFF, 4'hF);
    do_read(BASE, "R10 no alias entry 0");
    do_read(BASE + 4 * 3, "R10 no alias entry 3");
    do_read(BASE + 4 * (DEPTH - 1), "R10 last entry kept");
    do_read(BASE + WIN, "R10 miss reads zero");
    do_read(BASE - 1, "R10 miss below reads zero");
    do_read(BASE + 4 * (DEPTH - 1) + 3, "R1 R10 last byte of window");
    // held request while pending (R9)
    @(negedge clk_i);
    req_valid_i = 1; req_we_i = 0; req_addr_i = BASE + 4 * 2;
    @(posedge clk_i);
    @(negedge clk_i);
    req_we_i = 1; req_addr_i = BASE + 4 * 4; req_wdata_i = 32'h5A5A5A5A; req_be_i = 4'hF;
    check("R9 ready low", {29'h0, rdy}, 32'h0);
    for (int m = 0; m < 3; m++) check("R9 pending read data", rd[m], place(m, model[m][2]));
    @(posedge clk_i);
    @(negedge clk_i);
    req_valid_i = 0;
    do_read(BASE + 4 * 4, "R9 held write not accepted");
    // constrained random mix
    for (int k = 0; k < 600; k++) begin
      logic [31:0] a;
      a = ($urandom % 10 == 0) ? BASE + WIN + ($urandom % 64)
                               : BASE + ($urandom % (DEPTH * 4));
      if ($urandom % 2) do_write(a, $urandom, 4'($urandom));
      else do_read(a, "R1 R2 R3 R4 R5 R6 R7 R10 random");
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #1500000;
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule